// File: doc/BRIEF.md
# Dual Accumulator Arithmetic Unit

This block holds two 8-bit accumulators, A and B, and performs one arithmetic or transfer operation per clock on either of them. The two registers can also be treated as a single 16-bit accumulator D. D uses the same storage, with A as its upper byte and B as its lower byte. Each operation reads the chosen accumulator and combines it with a second operand. The operand is either an immediate value or a value taken from an outside register or memory. The result is then written back into that accumulator on the same clock edge.

A controller drives an operation code, a width select, an accumulator select and an operand-source select in each cycle. To combine two outside values, the controller first loads one of them, then adds or subtracts the other. The result is then read from one of the three accumulator views, which are always visible at the outputs. The carry, or borrow, out of the most significant bit of the active width is registered beside the accumulators.

Top module: `dual_acc_unit`

## Requirements
- R1: After reset, A, B and the carry flag are all zero.
- R2: A narrow load (op 2'b00, wide_i=0) writes the low byte of the operand into A when sel_b_i=0, or into B when sel_b_i=1. The other accumulator keeps its value.
- R3: A narrow add (op 2'b01) writes (acc + operand[7:0]) mod 256 into the selected accumulator. The carry flag becomes the carry out of bit 7.
- R4: A narrow subtract (op 2'b10) writes (acc - operand[7:0]) mod 256 into the selected accumulator. The carry flag becomes 1 exactly when the operand byte is greater than the accumulator (a borrow).
- R5: With wide_i=1, load, add and subtract act on D={A,B} with the full 16-bit operand. Both A and B take their new bytes on the same edge. The carry flag holds the carry or borrow out of bit 15, and sel_b_i has no effect.
- R6: Op 2'b11 (hold) leaves A, B and the carry flag unchanged.
- R7: With src_imm_i=1 the operand is imm_i; with src_imm_i=0 it is ext_i.
- R8: A load, narrow or wide, leaves the carry flag unchanged.
- R9: acc_d_o always equals {acc_a_o, acc_b_o}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation: 00 load, 01 add, 10 subtract, 11 hold |
| wide_i | input | 1 | 1 selects the 16-bit accumulator D |
| sel_b_i | input | 1 | Narrow target: 0 A, 1 B |
| src_imm_i | input | 1 | Operand source: 1 immediate, 0 external |
| imm_i | input | 16 | Immediate operand (low byte used when narrow) |
| ext_i | input | 16 | External register or memory operand |
| acc_a_o | output | 8 | Accumulator A |
| acc_b_o | output | 8 | Accumulator B |
| acc_d_o | output | 16 | Double accumulator view {A,B} |
| carry_o | output | 1 | Registered carry or borrow of the last add or subtract |

## Verification
All internal state is visible at the ports. A wrong accumulator byte or a wrong carry therefore shows on the outputs on the very edge that produces it, and the bench compares every output after every operation. A write-enable fault on the untouched accumulator shows up after the next narrow operation on the other one. A swapped byte order in D appears the first time a wide operation produces a carry across bit 7, or loads two unequal bytes. A carry that is wrongly updated during loads or holds stays on carry_o until the next add or subtract, so such a fault is caught in the cycle right after it happens.

// File: rtl/dual_acc_unit.sv
module dual_acc_unit #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     op_i,
  input  logic           wide_i,
  input  logic           sel_b_i,
  input  logic           src_imm_i,
  input  logic [2*W-1:0] imm_i,
  input  logic [2*W-1:0] ext_i,
  output logic [W-1:0]   acc_a_o,
  output logic [W-1:0]   acc_b_o,
  output logic [2*W-1:0] acc_d_o,
  output logic           carry_o
);
  localparam int DW = 2 * W;
  localparam logic [1:0] OP_LOAD = 2'b00;
  localparam logic [1:0] OP_ADD  = 2'b01;
  localparam logic [1:0] OP_SUB  = 2'b10;

  logic [W-1:0]  a_q, b_q;
  logic          c_q;
  logic [DW-1:0] opnd, cur, res;
  logic [DW:0]   sum, diff;
  logic          c_new;

  assign opnd = src_imm_i ? (wide_i ? imm_i : {{W{1'b0}}, imm_i[W-1:0]})
                          : (wide_i ? ext_i : {{W{1'b0}}, ext_i[W-1:0]});
  assign cur  = wide_i ? {a_q, b_q} : {{W{1'b0}}, (sel_b_i ? b_q : a_q)};
  assign sum  = {1'b0, cur} + {1'b0, opnd};
  assign diff = {1'b0, cur} - {1'b0, opnd};

  always_comb begin
    res   = opnd;
    c_new = c_q;
    case (op_i)
      OP_ADD: begin res = sum[DW-1:0];  c_new = wide_i ? sum[DW] : sum[W]; end
      OP_SUB: begin res = diff[DW-1:0]; c_new = diff[DW]; end
      default: begin res = opnd; c_new = c_q; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= 1'b0;
    end else if (op_i != 2'b11) begin
      c_q <= c_new;
      if (wide_i) begin
        a_q <= res[DW-1:W];
        b_q <= res[W-1:0];
      end else if (sel_b_i) begin
        b_q <= res[W-1:0];
      end else begin
        a_q <= res[W-1:0];
      end
    end
  end

  assign acc_a_o = a_q;
  assign acc_b_o = b_q;
  assign acc_d_o = {a_q, b_q};
  assign carry_o = c_q;
endmodule

module dual_acc_unit_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     op_i,
  input logic           wide_i,
  input logic           sel_b_i,
  input logic           src_imm_i,
  input logic [2*W-1:0] imm_i,
  input logic [2*W-1:0] ext_i,
  input logic [W-1:0]   acc_a_o,
  input logic [W-1:0]   acc_b_o,
  input logic [2*W-1:0] acc_d_o,
  input logic           carry_o
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 2'b11 |=> $stable(acc_a_o) && $stable(acc_b_o) && $stable(carry_o));

  p_other_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_i && sel_b_i) |=> $stable(acc_a_o));

  p_other_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_i && !sel_b_i) |=> $stable(acc_b_o));

  p_load_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 2'b00 |=> $stable(carry_o));

  p_load_imm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b00 && wide_i && src_imm_i) |=> acc_d_o == $past(imm_i));

  p_load_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'b00 && wide_i && !src_imm_i) |=> acc_d_o == $past(ext_i));

  always_comb begin
    p_d_view_r9: assert (acc_d_o == {acc_a_o, acc_b_o});
  end
endmodule

bind dual_acc_unit dual_acc_unit_chk #(.W(W)) chk_i (.*);

// File: tb/dual_acc_unit_tb_top.sv
module dual_acc_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] op_i = 2'b11;
  logic wide_i = 1'b0, sel_b_i = 1'b0, src_imm_i = 1'b0;
  logic [DW-1:0] imm_i = '0, ext_i = '0;
  logic [W-1:0] acc_a_o, acc_b_o;
  logic [DW-1:0] acc_d_o;
  logic carry_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] ma = '0, mb = '0;
  logic mc = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_acc_unit #(.W(W)) dut_i (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " A"}, 32'(acc_a_o), 32'(ma));
    check({tag, " B"}, 32'(acc_b_o), 32'(mb));
    check({tag, " C"}, 32'(carry_o), 32'(mc));
    check("R9 D view", 32'(acc_d_o), {16'd0, ma, mb});
  endtask

  function automatic logic [DW:0] model_step(input logic [1:0] op, input logic wide,
      input logic [DW-1:0] acc, input logic [DW-1:0] v, input logic c);
    logic [DW:0] r;
    r = {c, acc};
    if (wide) begin
      case (op)
        2'b00: r = {c, v};
        2'b01: r = {1'b0, acc} + {1'b0, v};
        2'b10: r = {(v > acc), acc - v};
        default: r = {c, acc};
      endcase
    end else begin
      case (op)
        2'b00: r = {c, 8'd0, v[7:0]};
        2'b01: r = {1'b0, 8'd0, acc[7:0] + v[7:0]} | {(({1'b0, acc[7:0]} + {1'b0, v[7:0]}) > 9'd255), 16'd0};
        2'b10: r = {(v[7:0] > acc[7:0]), 8'd0, acc[7:0] - v[7:0]};
        default: r = {c, acc};
      endcase
    end
    return r;
  endfunction

  task automatic do_op(input string tag, input logic [1:0] op, input logic wide, input logic selb,
      input logic simm, input logic [DW-1:0] imm, input logic [DW-1:0] ext);
    logic [DW:0] r;
    logic [DW-1:0] v;
    @(negedge clk);
    op_i = op; wide_i = wide; sel_b_i = selb; src_imm_i = simm; imm_i = imm; ext_i = ext;
    v = simm ? imm : ext;
    if (wide) begin
      r = model_step(op, 1'b1, {ma, mb}, v, mc);
      ma = r[15:8]; mb = r[7:0]; mc = r[16];
    end else begin
      r = model_step(op, 1'b0, {8'd0, selb ? mb : ma}, v, mc);
      if (selb) mb = r[7:0]; else ma = r[7:0];
      mc = r[16];
    end
    @(posedge clk); #1;
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #(CLK_PERIOD * 2 + 1);
    check_all("R1 reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check_all("R1 after release");

    do_op("R2 load A", 2'b00, 0, 0, 1, 16'hFFC8, 16'h1111);
    do_op("R2 load B", 2'b00, 0, 1, 0, 16'h2222, 16'hAB3C);
    do_op("R3 add wrap", 2'b01, 0, 0, 1, 16'h0038, 16'h0);
    check("R3 A=00", 32'(acc_a_o), 32'h00);
    check("R3 carry", 32'(carry_o), 32'd1);
    do_op("R8 load keeps carry", 2'b00, 0, 0, 1, 16'h0005, 16'h0);
    check("R8 carry", 32'(carry_o), 32'd1);
    do_op("R4 sub borrow", 2'b10, 0, 0, 0, 16'h0, 16'h0006);
    check("R4 A=FF", 32'(acc_a_o), 32'hFF);
    check("R4 borrow", 32'(carry_o), 32'd1);
    do_op("R4 sub equal", 2'b10, 0, 1, 1, 16'h003C, 16'h0);
    check("R4 no borrow", 32'(carry_o), 32'd0);
    do_op("R5 wide load", 2'b00, 1, 1, 1, 16'h12FF, 16'h0);
    check("R5 A msb", 32'(acc_a_o), 32'h12);
    do_op("R5 wide add cross", 2'b01, 1, 0, 0, 16'h0, 16'h0001);
    check("R5 D", 32'(acc_d_o), 32'h1300);
    check("R5 carry", 32'(carry_o), 32'd0);
    do_op("R5 wide add top", 2'b01, 1, 0, 1, 16'hED00, 16'h0);
    check("R5 carry15", 32'(carry_o), 32'd1);
    do_op("R5 wide sub", 2'b10, 1, 0, 1, 16'h0001, 16'h0);
    check("R5 D=FFFF", 32'(acc_d_o), 32'hFFFF);
    do_op("R6 hold", 2'b11, 1, 0, 1, 16'h5555, 16'hAAAA);
    do_op("R7 ext select", 2'b00, 1, 0, 0, 16'h1234, 16'hBEEF);
    check("R7 D", 32'(acc_d_o), 32'hBEEF);

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] op;
      op = 2'($urandom);
      do_op(op == 2'b11 ? "R6 rnd" : (op == 2'b00 ? "R2 rnd" : (op == 2'b01 ? "R3 rnd" : "R4 rnd")),
            op, 1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule